// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

This block turns the system clock into the two timing pulses that a serial transmitter needs. A 16-bit prescaler produces a one-cycle sample tick once every `prescale` clock cycles. A second 8-bit counter counts those sample ticks. It produces a one-cycle bit strobe once every `bit_div + 1` sample ticks. The bit period is therefore `prescale * (bit_div + 1)` clock cycles.

The divider inputs are captured only while `enable` is low. While the generator runs, it ignores changes on them. To apply new settings, software drops `enable`, drives the new values and raises `enable` again. Raising `enable` restarts both counters from zero. A prescale setting below 2 is illegal. In that case the generator stays silent and `cfg_ok` reports the fault.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `sample_tick`, `bit_strobe` and `cfg_ok` are all 0.
- R2: While running with a legal setting, `sample_tick` is a single-cycle pulse that repeats every `prescale` clock cycles. The first pulse appears `prescale` cycles after the first enabled clock edge.
- R3: `bit_strobe` is a single-cycle pulse that repeats every `prescale * (bit_div + 1)` cycles. It is high only in a cycle where `sample_tick` is also high, so each bit period contains exactly `bit_div + 1` sample ticks.
- R4: Counting from the first rising clock edge at which `enable` is sampled high, the first `bit_strobe` is seen exactly `prescale * (bit_div + 1)` cycles later.
- R5: With a captured `prescale` of 0 or 1, neither `sample_tick` nor `bit_strobe` ever pulses.
- R6: Changes on `prescale` and `bit_div` while `enable` is high have no effect on timing. They take effect only after `enable` has been low for at least one clock edge and is raised again.
- R7: One cycle after `enable` is sampled low, both outputs are 0 and stay 0. A later re-enable restarts both counters from zero, so the R4 timing holds again.
- R8: `cfg_ok` is 1 exactly when the captured `prescale` is 2 or more. While `enable` is low, it follows the `prescale` input with one cycle of lag. While `enable` is high, it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run when high; capture settings and clear counters when low |
| prescale | input | 16 | First-stage divide value (legal range 2 to 65535) |
| bit_div | input | 8 | Second-stage count; the bit period is this value plus one sample ticks |
| sample_tick | output | 1 | One-cycle pulse every `prescale` clocks |
| bit_strobe | output | 1 | One-cycle pulse at each bit boundary |
| cfg_ok | output | 1 | Captured prescale is legal |

## Verification
The bit period is measured from the enable edge and across a second period for several settings. These include the smallest legal prescale with bit_div at 4, a mid value, bit_div of 0 (strobe on every tick) and bit_div of 254. Between them they separate an off-by-one error in either stage from a mistake in the multiply rule. Prescale values of 0 and 1 confirm the silent, flagged state. A change of inputs during a run confirms that the run keeps its captured timing. A disable in mid-period followed by a re-enable confirms that both outputs go quiet and that the first strobe comes a full period after the restart.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int PRE_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [DIV_W-1:0] bit_div,
  output logic             sample_tick,
  output logic             bit_strobe,
  output logic             cfg_ok
);

  logic [PRE_W-1:0] pre_q, pre_cnt;
  logic [DIV_W-1:0] div_q, div_cnt;

  assign cfg_ok = (pre_q > PRE_W'(1));

  wire pre_wrap = (pre_cnt == pre_q - PRE_W'(1));
  wire div_wrap = (div_cnt == div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q       <= '0;
      div_q       <= '0;
      pre_cnt     <= '0;
      div_cnt     <= '0;
      sample_tick <= 1'b0;
      bit_strobe  <= 1'b0;
    end else if (!enable) begin
      pre_q       <= prescale;
      div_q       <= bit_div;
      pre_cnt     <= '0;
      div_cnt     <= '0;
      sample_tick <= 1'b0;
      bit_strobe  <= 1'b0;
    end else if (!cfg_ok) begin
      pre_cnt     <= '0;
      div_cnt     <= '0;
      sample_tick <= 1'b0;
      bit_strobe  <= 1'b0;
    end else if (pre_wrap) begin
      pre_cnt     <= '0;
      sample_tick <= 1'b1;
      bit_strobe  <= div_wrap;
      div_cnt     <= div_wrap ? '0 : div_cnt + DIV_W'(1);
    end else begin
      pre_cnt     <= pre_cnt + PRE_W'(1);
      sample_tick <= 1'b0;
      bit_strobe  <= 1'b0;
    end
  end

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sample_tick,
  input logic bit_strobe,
  input logic cfg_ok
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!sample_tick && !bit_strobe && !cfg_ok));

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  assert_strobe_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> sample_tick);

  assert_illegal_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> (!sample_tick && !bit_strobe));

  assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(cfg_ok));

  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sample_tick && !bit_strobe));

endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .sample_tick(sample_tick), .bit_strobe(bit_strobe), .cfg_ok(cfg_ok)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [15:0] prescale = 16'd0;
  logic [7:0] bit_div = 8'd0;
  logic sample_tick, bit_strobe, cfg_ok;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
    .bit_div(bit_div), .sample_tick(sample_tick), .bit_strobe(bit_strobe),
    .cfg_ok(cfg_ok)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input int pre, input int bd);
    enable = 1'b0;
    prescale = 16'(pre);
    bit_div = 8'(bd);
    step();
    step();
  endtask

  task automatic wait_strobe(input int limit, output int k, output int ticks, output int first_tick);
    k = 0;
    ticks = 0;
    first_tick = -1;
    do begin
      step();
      k++;
      if (sample_tick) begin
        ticks++;
        if (first_tick < 0) first_tick = k;
      end
    end while (!bit_strobe && k < limit);
  endtask

  task automatic test_reset();
    chk(!sample_tick && !bit_strobe, "R1 ticks", int'(sample_tick) + int'(bit_strobe), 0);
    chk(!cfg_ok, "R1 cfg_ok", int'(cfg_ok), 0);
  endtask

  task automatic test_period(input int pre, input int bd);
    int n, k, ticks, ft;
    n = pre * (bd + 1);
    setup(pre, bd);
    chk(cfg_ok, "R8 legal flag", int'(cfg_ok), 1);
    enable = 1'b1;
    wait_strobe(n + 10, k, ticks, ft);
    chk(k == n, "R4 first strobe", k, n);
    chk(ft == pre, "R2 first tick", ft, pre);
    chk(ticks == bd + 1, "R3 ticks per bit", ticks, bd + 1);
    wait_strobe(n + 10, k, ticks, ft);
    chk(k == n, "R3 strobe period", k, n);
    chk(ticks == bd + 1, "R3 ticks per bit", ticks, bd + 1);
    if (bd > 0) chk(ft == pre, "R2 tick period", ft, pre);
    enable = 1'b0;
    step();
  endtask

  task automatic test_illegal(input int pre);
    int ticks;
    setup(pre, 4);
    chk(!cfg_ok, "R8 illegal flag", int'(cfg_ok), 0);
    enable = 1'b1;
    ticks = 0;
    for (int i = 0; i < 100; i++) begin
      step();
      if (sample_tick || bit_strobe) ticks++;
    end
    chk(ticks == 0, "R5 no pulses", ticks, 0);
    chk(!cfg_ok, "R5 flag low while enabled", int'(cfg_ok), 0);
    enable = 1'b0;
    step();
  endtask

  task automatic test_ignore_change();
    int k, ticks, ft;
    setup(4, 4);
    enable = 1'b1;
    step();
    step();
    step();
    prescale = 16'd0;
    bit_div = 8'd0;
    wait_strobe(40, k, ticks, ft);
    chk(k + 3 == 20, "R6 run keeps captured timing", k + 3, 20);
    chk(cfg_ok, "R6 flag held", int'(cfg_ok), 1);
    enable = 1'b0;
    prescale = 16'd2;
    step();
    enable = 1'b1;
    wait_strobe(40, k, ticks, ft);
    chk(k == 2, "R6 new values after re-enable", k, 2);
    enable = 1'b0;
    step();
  endtask

  task automatic test_disable();
    int k, ticks, ft, seen;
    setup(5, 4);
    enable = 1'b1;
    for (int i = 0; i < 12; i++) step();
    enable = 1'b0;
    step();
    chk(!sample_tick && !bit_strobe, "R7 quiet after disable", int'(sample_tick) + int'(bit_strobe), 0);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (sample_tick || bit_strobe) seen++;
    end
    chk(seen == 0, "R7 stays quiet", seen, 0);
    enable = 1'b1;
    wait_strobe(40, k, ticks, ft);
    chk(k == 25, "R7 restart from zero", k, 25);
    enable = 1'b0;
    step();
  endtask

  task automatic test_flag_follow();
    setup(1, 0);
    chk(!cfg_ok, "R8 follows input low", int'(cfg_ok), 0);
    prescale = 16'd9;
    step();
    chk(cfg_ok, "R8 follows input high", int'(cfg_ok), 1);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step();
    step();
    test_reset();
    rst_n = 1'b1;
    step();
    test_reset();
    test_period(2, 4);
    test_period(3, 4);
    test_period(10, 7);
    test_period(6, 0);
    test_period(7, 254);
    test_period(300, 4);
    test_illegal(0);
    test_illegal(1);
    test_ignore_change();
    test_disable();
    test_flag_follow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule